// File: doc/BRIEF.md
# GCI Frame Channel Demultiplexer

This block is the layer-1 end of a serial control bus that carries one 32-bit frame per sync pulse. It runs on the bus bit clock, which toggles at twice the data rate, so every frame bit occupies two clock cycles. The first edge of a bit period launches the transmit bit and the second edge samples the receive bit. Each received frame is split into its channels: two bearer bytes (B1, B2), a monitor byte, a two-bit signalling field (D), a four-bit command/indication field (CI) and the two single bits A and E. Each channel appears on its own parallel port with a one-cycle valid strobe. In the other direction, the same channel set is taken from parallel inputs and serialised onto the transmit line.

A 32-bit enable mask, one bit per frame position, chooses which bit positions take part in the exchange. Disabled positions are neither captured nor driven: the transmit line stays high there. The mask and the transmit channel values are latched on the frame-start edge, so software-side changes take effect only at frame boundaries. The serial side cannot stall, so the parallel outputs are plain strobes with no ready: a consumer must take each value in the cycle its strobe is high. After that the value is held until the same channel completes again.

Top module: `gci_frame_demux`

## Requirements
- R1: Frame bit positions (first transmitted = 0) map to fields as B1 0..7, B2 8..15, monitor 16..23, D 24..25, CI 26..29, A 30, E 31. Within each field the earliest bit is the most significant bit of the parallel value. Bit n of the enable mask governs frame position n.
- R2: A rising clock edge that sees `fsync` high is edge 0 of a frame. Position i has its first edge at edge 2i, and `rxd` is sampled at edge 2i+1.
- R3: A received field value holds the sampled `rxd` bits at enabled positions and 0 at disabled positions.
- R4: A field's valid strobe is high for exactly the one cycle after edge 2L+1, where L is the field's last position, and only if at least one of its positions is enabled. The field port carries the new value while the strobe is high and keeps it afterwards.
- R5: At edge 2i, `txd` takes the field bit for position i if that position is enabled, and 1 if it is not.
- R6: `txd` is 1 after reset. It returns to 1 at edge 64 and stays there until the next `fsync`, and no strobe fires in that idle time.
- R7: The mask and the transmit field inputs are latched at edge 0. Changing them later in the frame has no effect on that frame's capture, strobes or `txd`.
- R8: An `fsync` during a frame restarts at position 0 with cleared capture state. Fields of the abandoned frame that had not completed give no strobe.
- R9: An `fsync` at edge 64 starts a new frame directly. `txd` goes straight to the new position-0 value, and the old frame's E strobe still appears in the cycle before.
- R10: During and right after reset, all strobes are 0, all received field ports are 0 and `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock, twice the data rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, sampled on rising edges |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| en_mask | input | 32 | Per-position enable, latched at frame start |
| tx_b1 | input | 8 | First bearer byte to send |
| tx_b2 | input | 8 | Second bearer byte to send |
| tx_mon | input | 8 | Monitor byte to send |
| tx_d | input | 2 | D field to send |
| tx_ci | input | 4 | CI field to send |
| tx_a | input | 1 | A bit to send |
| tx_e | input | 1 | E bit to send |
| rx_b1 | output | 8 | Received first bearer byte |
| rx_b1_vld | output | 1 | Strobe for rx_b1 |
| rx_b2 | output | 8 | Received second bearer byte |
| rx_b2_vld | output | 1 | Strobe for rx_b2 |
| rx_mon | output | 8 | Received monitor byte |
| rx_mon_vld | output | 1 | Strobe for rx_mon |
| rx_d | output | 2 | Received D field |
| rx_d_vld | output | 1 | Strobe for rx_d |
| rx_ci | output | 4 | Received CI field |
| rx_ci_vld | output | 1 | Strobe for rx_ci |
| rx_a | output | 1 | Received A bit |
| rx_a_vld | output | 1 | Strobe for rx_a |
| rx_e | output | 1 | Received E bit |
| rx_e_vld | output | 1 | Strobe for rx_e |

## Verification
The two functions that share a cycle are the end of one frame and the start of the next. The E strobe of the finishing frame is high in the very cycle in which a new `fsync` is sampled, and that same edge must latch a fresh mask and overrule the return of `txd` to idle. This is provoked by issuing the next sync immediately after position 31, and is judged by checking the E strobe and value before that edge and the new position-0 `txd` after it. A second overlap, a sync arriving mid-frame while a field is half captured, is judged by the missing strobe for that field and by the zeroed disabled bits of the restarted frame.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int FRAME_BITS = 32;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int NUM_FIELDS = 7;
  localparam int BYTE_W     = 8;
  localparam int D_W        = 2;
  localparam int CI_W       = 4;

  typedef enum int {F_B1 = 0, F_B2, F_MON, F_D, F_CI, F_A, F_E} field_e;

  function automatic int fld_lo(input int f);
    case (f)
      F_B1:    return 0;
      F_B2:    return BYTE_W;
      F_MON:   return 2 * BYTE_W;
      F_D:     return 3 * BYTE_W;
      F_CI:    return 3 * BYTE_W + D_W;
      F_A:     return 3 * BYTE_W + D_W + CI_W;
      default: return 3 * BYTE_W + D_W + CI_W + 1;
    endcase
  endfunction

  function automatic int fld_len(input int f);
    case (f)
      F_B1, F_B2, F_MON: return BYTE_W;
      F_D:               return D_W;
      F_CI:              return CI_W;
      default:           return 1;
    endcase
  endfunction

  // Position mirrored inside its own field (earliest bit <-> MSB).
  function automatic int fld_mirror(input int i);
    int m;
    m = i;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      if (i >= fld_lo(f) && i < fld_lo(f) + fld_len(f))
        m = 2 * fld_lo(f) + fld_len(f) - 1 - i;
    end
    return m;
  endfunction

  // Converts between frame order and packed field-value order (involution).
  function automatic logic [FRAME_BITS-1:0] fld_flip(input logic [FRAME_BITS-1:0] w);
    logic [FRAME_BITS-1:0] r;
    r = '0;
    for (int i = 0; i < FRAME_BITS; i++) r[fld_mirror(i)] = w[i];
    return r;
  endfunction
endpackage

// File: rtl/gci_timing.sv
module gci_timing
  import gci_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             rx_smp,
  output logic             tx_adv,
  output logic             tx_end
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_BITS - 1);

  // ph = 0: between the launch edge and the sample edge of position idx
  logic ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= 1'b0;
      idx    <= '0;
    end else if (fsync) begin
      active <= 1'b1;
      ph     <= 1'b0;
      idx    <= '0;
    end else if (active) begin
      if (!ph) begin
        ph <= 1'b1;
      end else begin
        ph <= 1'b0;
        if (idx == LAST) active <= 1'b0;
        else             idx    <= idx + 1'b1;
      end
    end
  end

  assign rx_smp = active && !ph && !fsync;
  assign tx_adv = active &&  ph && !fsync && (idx != LAST);
  assign tx_end = active &&  ph && !fsync && (idx == LAST);

  AST_BIT_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    rx_smp |=> (active && ph && $stable(idx)));  // R2
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    tx_end |=> !active);  // R6
endmodule

// File: rtl/gci_rx.sv
module gci_rx
  import gci_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  rx_smp,
  input  logic [IDX_W-1:0]      idx,
  input  logic                  rxd,
  input  logic [FRAME_BITS-1:0] mask_in,
  output logic [FRAME_BITS-1:0] fld_val,
  output logic [NUM_FIELDS-1:0] fld_vld
);
  logic [FRAME_BITS-1:0] en_q;
  logic [FRAME_BITS-1:0] asm_q;
  logic [FRAME_BITS-1:0] asm_nxt;
  logic [FRAME_BITS-1:0] asm_packed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      asm_q <= '0;
    end else if (fsync) begin
      en_q  <= mask_in;
      asm_q <= '0;
    end else begin
      asm_q <= asm_nxt;
    end
  end

  always_comb begin
    asm_nxt = asm_q;
    if (rx_smp) asm_nxt[idx] = rxd & en_q[idx];
  end

  assign asm_packed = fld_flip(asm_nxt);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int LO  = fld_lo(f);
    localparam int LEN = fld_len(f);
    localparam int HI  = LO + LEN - 1;

    logic           last_hit;
    logic           any_en;
    logic [LEN-1:0] val_q;
    logic           vld_q;

    assign last_hit = rx_smp && (idx == IDX_W'(HI));
    assign any_en   = |en_q[HI:LO];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= last_hit && any_en;
        if (last_hit && any_en) val_q <= asm_packed[HI:LO];
      end
    end

    assign fld_val[HI:LO] = val_q;
    assign fld_vld[f]     = vld_q;
  end

  AST_VLD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fld_vld));  // R4
  AST_VLD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_smp |=> (fld_vld == '0));  // R4
endmodule

// File: rtl/gci_tx.sv
module gci_tx
  import gci_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  active,
  input  logic                  tx_adv,
  input  logic                  tx_end,
  input  logic [IDX_W-1:0]      idx,
  input  logic [FRAME_BITS-1:0] mask_in,
  input  logic [FRAME_BITS-1:0] fld_in,
  output logic                  txd
);
  logic [FRAME_BITS-1:0] en_q;
  logic [FRAME_BITS-1:0] dat_q;
  logic [FRAME_BITS-1:0] frame_in;
  logic [IDX_W-1:0]      nxt;

  assign frame_in = fld_flip(fld_in);
  assign nxt      = idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dat_q <= '0;
      txd   <= 1'b1;
    end else if (fsync) begin
      en_q  <= mask_in;
      dat_q <= frame_in;
      txd   <= mask_in[0] ? frame_in[0] : 1'b1;
    end else if (tx_adv) begin
      txd   <= en_q[nxt] ? dat_q[nxt] : 1'b1;
    end else if (tx_end) begin
      txd   <= 1'b1;
    end
  end

  AST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> txd);  // R6
  AST_TX_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (en_q[idx] || txd));  // R5
endmodule

// File: rtl/gci_frame_demux.sv
module gci_frame_demux
  import gci_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic                  rxd,
  output logic                  txd,
  input  logic [FRAME_BITS-1:0] en_mask,
  input  logic [BYTE_W-1:0]     tx_b1,
  input  logic [BYTE_W-1:0]     tx_b2,
  input  logic [BYTE_W-1:0]     tx_mon,
  input  logic [D_W-1:0]        tx_d,
  input  logic [CI_W-1:0]       tx_ci,
  input  logic                  tx_a,
  input  logic                  tx_e,
  output logic [BYTE_W-1:0]     rx_b1,
  output logic                  rx_b1_vld,
  output logic [BYTE_W-1:0]     rx_b2,
  output logic                  rx_b2_vld,
  output logic [BYTE_W-1:0]     rx_mon,
  output logic                  rx_mon_vld,
  output logic [D_W-1:0]        rx_d,
  output logic                  rx_d_vld,
  output logic [CI_W-1:0]       rx_ci,
  output logic                  rx_ci_vld,
  output logic                  rx_a,
  output logic                  rx_a_vld,
  output logic                  rx_e,
  output logic                  rx_e_vld
);
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             rx_smp;
  logic             tx_adv;
  logic             tx_end;

  logic [FRAME_BITS-1:0] tx_fld;
  logic [FRAME_BITS-1:0] rx_fld;
  logic [NUM_FIELDS-1:0] rx_vld;

  assign tx_fld = {tx_e, tx_a, tx_ci, tx_d, tx_mon, tx_b2, tx_b1};

  gci_timing u_timing (
    .clk    (clk),
    .rst_n  (rst_n),
    .fsync  (fsync),
    .active (active),
    .idx    (idx),
    .rx_smp (rx_smp),
    .tx_adv (tx_adv),
    .tx_end (tx_end)
  );

  gci_rx u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .rx_smp  (rx_smp),
    .idx     (idx),
    .rxd     (rxd),
    .mask_in (en_mask),
    .fld_val (rx_fld),
    .fld_vld (rx_vld)
  );

  gci_tx u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .active  (active),
    .tx_adv  (tx_adv),
    .tx_end  (tx_end),
    .idx     (idx),
    .mask_in (en_mask),
    .fld_in  (tx_fld),
    .txd     (txd)
  );

  assign {rx_e, rx_a, rx_ci, rx_d, rx_mon, rx_b2, rx_b1} = rx_fld;
  assign rx_b1_vld  = rx_vld[F_B1];
  assign rx_b2_vld  = rx_vld[F_B2];
  assign rx_mon_vld = rx_vld[F_MON];
  assign rx_d_vld   = rx_vld[F_D];
  assign rx_ci_vld  = rx_vld[F_CI];
  assign rx_a_vld   = rx_vld[F_A];
  assign rx_e_vld   = rx_vld[F_E];

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> (txd && !fsync));  // R6
endmodule

// File: tb/gci_frame_demux_tb.sv
`timescale 1ns/1ps
module gci_frame_demux_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fsync = 1'b0;
  logic rxd = 1'b0;
  logic txd;
  logic [31:0] en_mask = '0;
  logic [7:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
  logic [1:0] tx_d = '0;
  logic [3:0] tx_ci = '0;
  logic tx_a = 1'b0, tx_e = 1'b0;
  logic [7:0] rx_b1, rx_b2, rx_mon;
  logic [1:0] rx_d;
  logic [3:0] rx_ci;
  logic rx_a, rx_e;
  logic rx_b1_vld, rx_b2_vld, rx_mon_vld, rx_d_vld, rx_ci_vld, rx_a_vld, rx_e_vld;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  gci_frame_demux u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .rxd(rxd), .txd(txd),
    .en_mask(en_mask), .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon),
    .tx_d(tx_d), .tx_ci(tx_ci), .tx_a(tx_a), .tx_e(tx_e),
    .rx_b1(rx_b1), .rx_b1_vld(rx_b1_vld), .rx_b2(rx_b2), .rx_b2_vld(rx_b2_vld),
    .rx_mon(rx_mon), .rx_mon_vld(rx_mon_vld), .rx_d(rx_d), .rx_d_vld(rx_d_vld),
    .rx_ci(rx_ci), .rx_ci_vld(rx_ci_vld), .rx_a(rx_a), .rx_a_vld(rx_a_vld),
    .rx_e(rx_e), .rx_e_vld(rx_e_vld)
  );

  // Field table of R1
  function automatic int t_lo(input int f);
    int lo[7] = '{0, 8, 16, 24, 26, 30, 31};
    return lo[f];
  endfunction
  function automatic int t_len(input int f);
    int ln[7] = '{8, 8, 8, 2, 4, 1, 1};
    return ln[f];
  endfunction
  function automatic logic [7:0] fval(input logic [31:0] w, input int f);
    logic [7:0] r = '0;
    for (int k = 0; k < t_len(f); k++) r[t_len(f)-1-k] = w[t_lo(f)+k];
    return r;
  endfunction

  logic [6:0] obs_vld;
  logic [7:0] obs_dat [7];
  always_comb begin
    obs_vld = {rx_e_vld, rx_a_vld, rx_ci_vld, rx_d_vld, rx_mon_vld, rx_b2_vld, rx_b1_vld};
    obs_dat[0] = rx_b1;
    obs_dat[1] = rx_b2;
    obs_dat[2] = rx_mon;
    obs_dat[3] = {6'b0, rx_d};
    obs_dat[4] = {4'b0, rx_ci};
    obs_dat[5] = {7'b0, rx_a};
    obs_dat[6] = {7'b0, rx_e};
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_tx(input logic [31:0] w);
    tx_b1  = fval(w, 0);
    tx_b2  = fval(w, 1);
    tx_mon = fval(w, 2);
    tx_d   = fval(w, 3)[1:0];
    tx_ci  = fval(w, 4)[3:0];
    tx_a   = w[30];
    tx_e   = w[31];
  endtask

  // One frame; ncyc < 64 abandons it early; garble changes inputs mid-frame (R7)
  task automatic run_frame(input logic [31:0] mask, input logic [31:0] rxw,
                           input logic [31:0] txw, input int ncyc,
                           input bit garble, input string req);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      fsync = (c == 0);
      rxd   = rxw[c/2];
      if (c == 0) begin
        en_mask = mask;
        drive_tx(txw);
      end
      if (garble && c == 6) begin
        en_mask = ~mask;
        drive_tx(~txw);
      end
      @(posedge clk);
      #1;
      chk(txd === (mask[c/2] ? txw[c/2] : 1'b1), {req, " R5 R2"}, "txd",
          {31'b0, txd}, {31'b0, mask[c/2] ? txw[c/2] : 1'b1});
      for (int f = 0; f < 7; f++) begin
        automatic int hi = t_lo(f) + t_len(f) - 1;
        automatic bit any = |(mask & (((32'h1 << t_len(f)) - 1) << t_lo(f)));
        automatic bit ev = (c == 2*hi + 1) && any;
        if (obs_vld[f] !== ev)
          chk(1'b0, {req, " R4"}, $sformatf("vld field %0d cyc %0d", f, c),
              {31'b0, obs_vld[f]}, {31'b0, ev});
        else if (ev)
          chk(obs_dat[f] === fval(rxw & mask, f), {req, " R1 R3"},
              $sformatf("data field %0d", f), {24'b0, obs_dat[f]},
              {24'b0, fval(rxw & mask, f)});
      end
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      fsync = 1'b0;
      rxd   = c[0];
      @(posedge clk);
      #1;
      chk(txd === 1'b1 && obs_vld == '0, "R6", "idle txd/vld",
          {24'b0, obs_vld, txd}, 32'h1);
    end
  endtask

  localparam logic [95:0] VEC [6] = '{
    {32'hFFFF_FFFF, 32'hA5C3_3C5A, 32'h1234_5678},
    {32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0000_00FF, 32'hDEAD_BEEF, 32'h0F0F_0F0F},
    {32'hAAAA_AAAA, 32'h1357_9BDF, 32'h2468_ACE0},
    {32'hC000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h3F00_0000, 32'h5A5A_5A5A, 32'hC3C3_C3C3}
  };

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired act=1 exp=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(txd === 1'b1 && obs_vld == '0, "R10", "reset txd/vld", {24'b0, obs_vld, txd}, 32'h1);
    chk({rx_e, rx_a, rx_ci, rx_d, rx_mon, rx_b2, rx_b1} === 32'h0, "R10", "reset data",
        {rx_e, rx_a, rx_ci, rx_d, rx_mon, rx_b2, rx_b1}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    for (int v = 0; v < 6; v++) begin
      run_frame(VEC[v][95:64], VEC[v][63:32], VEC[v][31:0], 64, 1'b0, "R1");
      idle(3);
    end

    // Mid-frame input changes must not matter (R7)
    run_frame(32'h00FF_F00F, 32'h6B3D_91C4, 32'h9E2A_55F1, 64, 1'b1, "R7");
    idle(2);

    // Back-to-back frames (R9): E strobe before, new bit 0 right after
    run_frame(32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 64, 1'b0, "R9");
    run_frame(32'hFFFF_FFFE, 32'h0000_0000, 32'h0000_0000, 64, 1'b0, "R9");
    run_frame(32'hFFFF_FFFF, 32'hC3A5_0F96, 32'h7FFF_FFFE, 64, 1'b0, "R9");
    idle(2);

    // Mid-frame restart (R8): abandon after position 10, new frame enables part of B2
    run_frame(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 22, 1'b0, "R8");
    run_frame(32'hFFFF_F0FF, 32'h0000_FF00, 32'h5555_AAAA, 64, 1'b0, "R8");
    idle(4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule